// File: doc/BRIEF.md
# Clustered Duplicated Integer Register File

This block holds the physical integer registers of a two-cluster execution core as two identical copies. Each cluster owns one copy, and that copy serves only the integer unit and the load/store unit of its own cluster. Every copy therefore needs only four read ports: two source operands for each of its two units. Storage is duplicated so that read ports are not shared between clusters.

Every result goes into both copies. A result written by a cluster enters that cluster's own copy at the end of the writing cycle, and a same-cycle read of that tag in that cluster already sees it through a bypass. The result crosses to the peer cluster through a one-cycle register stage and lands in the peer copy one clock later. During that one cycle the two copies disagree about the tag, and a read in the peer cluster still returns the old value.

There are 80 physical tags: 0 to 31 hold architectural registers, 32 to 71 rename registers and 72 to 79 privileged shadow registers. The always-zero register is not a tag. Every read and write port carries a separate zero-select flag for it. Reset is asynchronous and active-low, and it is released into the block through a two-flop synchronizer.

Top module: `dual_copy_int_regfile`

## Requirements
- R1: After reset every one of the 80 entries reads zero in both copies, and no delayed cross-cluster write is pending.
- R2: A read port whose zero-select flag is set returns all zeros, whatever its tag and whatever the copy holds.
- R3: A write port whose zero-select flag is set changes no entry in either copy and sends nothing across to the peer.
- R4: A write from cluster c updates copy c at the clock edge that ends the write cycle. A read of the same tag in cluster c during the write cycle returns the new data through a bypass.
- R5: The same write is captured by the cross-cluster stage at that edge and lands in the peer copy one edge later. A peer read during the write cycle and during the following cycle returns the old value.
- R6: Two clock edges after a write, both copies return the same value for the written tag.
- R7: When both write ports of one cluster target the same tag in one cycle, port 1 wins. This holds for the bypass and for both copies.
- R8: Tags 0 to 79 each store a full 64-bit value independently, across the architectural, rename and shadow ranges. Tags 80 to 127 read zero, and writes to them are discarded without aliasing onto any stored entry.
- R9: A local write and a landing cross-cluster write to the same tag of one copy in the same cycle is illegal. A checker flags it, and the local write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, synchronized inside |
| rd_zero_i | input | 2x4 | Per cluster and read port: read the always-zero register |
| rd_tag_i | input | 2x4x7 | Per cluster and read port: physical tag |
| rd_data_o | output | 2x4x64 | Per cluster and read port: read value from that cluster's copy |
| wr_en_i | input | 2x2 | Per cluster and write port: write request |
| wr_zero_i | input | 2x2 | Per cluster and write port: target is the always-zero register (write dropped) |
| wr_tag_i | input | 2x2x7 | Per cluster and write port: destination tag |
| wr_data_i | input | 2x2x64 | Per cluster and write port: result value |

## Verification
The bench builds the block with its default parameters: 32 architectural, 40 rename and 8 shadow entries of 64 bits, four read ports and two write ports per cluster. This gives a 7-bit tag, so tags 80 to 127 can be driven, and aliasing or out-of-range writes become visible. The bench keeps a reference model of both copies with a pending queue for cross-cluster writes. That model gives the expected value at each sampled phase: the write cycle, the skew cycle and after landing. Streams of back-to-back writes from both clusters exercise the stage while it is continuously busy.

// File: rtl/dcrf_pkg.sv
package dcrf_pkg;

  // The register file is duplicated across exactly two execution clusters.
  localparam int NUM_CLUSTERS = 2;

  // Default sizing of the physical tag space.
  localparam int DEF_ARCH_REGS   = 32;
  localparam int DEF_RENAME_REGS = 40;
  localparam int DEF_SHADOW_REGS = 8;
  localparam int DEF_DATA_W      = 64;

  // Cluster that receives a given cluster's results one cycle late.
  function automatic int peer_of(input int cl);
    return (cl + 1) % NUM_CLUSTERS;
  endfunction

endpackage

// File: rtl/dcrf_rst_sync.sv
module dcrf_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [1:0] sync_d;
  logic [1:0] sync_q;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[1];

endmodule

// File: rtl/dcrf_xfer_stage.sv
// One-cycle register stage that carries a cluster's writes to its peer copy.
module dcrf_xfer_stage #(
  parameter int WR_PORTS = 2,
  parameter int TAG_W    = 7,
  parameter int DATA_W   = 64
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [WR_PORTS-1:0]              wr_en_i,
  input  logic [WR_PORTS-1:0]              wr_zero_i,
  input  logic [WR_PORTS-1:0][TAG_W-1:0]   wr_tag_i,
  input  logic [WR_PORTS-1:0][DATA_W-1:0]  wr_data_i,
  output logic [WR_PORTS-1:0]              xfer_vld_o,
  output logic [WR_PORTS-1:0][TAG_W-1:0]   xfer_tag_o,
  output logic [WR_PORTS-1:0][DATA_W-1:0]  xfer_data_o
);

  logic [WR_PORTS-1:0]             vld_d;
  logic [WR_PORTS-1:0]             vld_q;
  logic [WR_PORTS-1:0][TAG_W-1:0]  tag_q;
  logic [WR_PORTS-1:0][DATA_W-1:0] data_q;

  // Writes to the zero register never cross over.
  always_comb begin
    vld_d = wr_en_i & ~wr_zero_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
    end else begin
      vld_q <= vld_d;
    end
  end

  // Payload is only loaded when a write actually crosses.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q  <= '0;
      data_q <= '0;
    end else begin
      for (int w = 0; w < WR_PORTS; w++) begin
        if (vld_d[w]) begin
          tag_q[w]  <= wr_tag_i[w];
          data_q[w] <= wr_data_i[w];
        end
      end
    end
  end

  assign xfer_vld_o  = vld_q;
  assign xfer_tag_o  = tag_q;
  assign xfer_data_o = data_q;

endmodule

// File: rtl/dcrf_bank.sv
// One copy of the register file: local write ports with read bypass,
// delayed remote write ports, and the read ports of one cluster.
module dcrf_bank #(
  parameter int NUM_ENTRIES = 80,
  parameter int DATA_W      = 64,
  parameter int RD_PORTS    = 4,
  parameter int WR_PORTS    = 2,
  parameter int TAG_W       = 7
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  // writes produced in this cluster
  input  logic [WR_PORTS-1:0]              lcl_en_i,
  input  logic [WR_PORTS-1:0]              lcl_zero_i,
  input  logic [WR_PORTS-1:0][TAG_W-1:0]   lcl_tag_i,
  input  logic [WR_PORTS-1:0][DATA_W-1:0]  lcl_data_i,
  // writes produced in the peer cluster one cycle earlier
  input  logic [WR_PORTS-1:0]              rem_vld_i,
  input  logic [WR_PORTS-1:0][TAG_W-1:0]   rem_tag_i,
  input  logic [WR_PORTS-1:0][DATA_W-1:0]  rem_data_i,
  // reads
  input  logic [RD_PORTS-1:0]              rd_zero_i,
  input  logic [RD_PORTS-1:0][TAG_W-1:0]   rd_tag_i,
  output logic [RD_PORTS-1:0][DATA_W-1:0]  rd_data_o
);

  localparam logic [TAG_W-1:0] LAST_TAG = TAG_W'(NUM_ENTRIES - 1);

  logic [DATA_W-1:0]   mem_q [NUM_ENTRIES];
  logic [DATA_W-1:0]   mem_d [NUM_ENTRIES];
  logic [WR_PORTS-1:0] lcl_ok;
  logic [WR_PORTS-1:0] rem_ok;
  logic                bank_we;

  // Qualify writes: real register, tag inside the storage range.
  always_comb begin
    for (int w = 0; w < WR_PORTS; w++) begin
      lcl_ok[w] = lcl_en_i[w] & ~lcl_zero_i[w] & (lcl_tag_i[w] <= LAST_TAG);
      rem_ok[w] = rem_vld_i[w] & (rem_tag_i[w] <= LAST_TAG);
    end
  end

  assign bank_we = |{lcl_ok, rem_ok};

  // Next state: remote writes first, then local ones so that local wins;
  // within each group the higher port index is applied last and wins.
  always_comb begin
    mem_d = mem_q;
    for (int w = 0; w < WR_PORTS; w++) begin
      if (rem_ok[w]) begin
        mem_d[rem_tag_i[w]] = rem_data_i[w];
      end
    end
    for (int w = 0; w < WR_PORTS; w++) begin
      if (lcl_ok[w]) begin
        mem_d[lcl_tag_i[w]] = lcl_data_i[w];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        mem_q[i] <= '0;
      end
    end else if (bank_we) begin
      mem_q <= mem_d;
    end
  end

  // Reads: stored value, overridden by same-cycle local writes (not by
  // remote ones), forced to zero for the zero register.
  always_comb begin
    for (int p = 0; p < RD_PORTS; p++) begin
      if (rd_tag_i[p] <= LAST_TAG) begin
        rd_data_o[p] = mem_q[rd_tag_i[p]];
      end else begin
        rd_data_o[p] = '0;
      end
      for (int w = 0; w < WR_PORTS; w++) begin
        if (lcl_ok[w] && (lcl_tag_i[w] == rd_tag_i[p])) begin
          rd_data_o[p] = lcl_data_i[w];
        end
      end
      if (rd_zero_i[p]) begin
        rd_data_o[p] = '0;
      end
    end
  end

endmodule

// File: rtl/dual_copy_int_regfile.sv
module dual_copy_int_regfile
  import dcrf_pkg::*;
#(
  parameter  int ARCH_REGS   = DEF_ARCH_REGS,
  parameter  int RENAME_REGS = DEF_RENAME_REGS,
  parameter  int SHADOW_REGS = DEF_SHADOW_REGS,
  parameter  int DATA_W      = DEF_DATA_W,
  parameter  int RD_PORTS    = 4,
  parameter  int WR_PORTS    = 2,
  localparam int NUM_ENTRIES = ARCH_REGS + RENAME_REGS + SHADOW_REGS,
  localparam int TAG_W       = $clog2(NUM_ENTRIES)
) (
  input  logic                                                 clk_i,
  input  logic                                                 rst_ni,
  input  logic [NUM_CLUSTERS-1:0][RD_PORTS-1:0]                rd_zero_i,
  input  logic [NUM_CLUSTERS-1:0][RD_PORTS-1:0][TAG_W-1:0]     rd_tag_i,
  output logic [NUM_CLUSTERS-1:0][RD_PORTS-1:0][DATA_W-1:0]    rd_data_o,
  input  logic [NUM_CLUSTERS-1:0][WR_PORTS-1:0]                wr_en_i,
  input  logic [NUM_CLUSTERS-1:0][WR_PORTS-1:0]                wr_zero_i,
  input  logic [NUM_CLUSTERS-1:0][WR_PORTS-1:0][TAG_W-1:0]     wr_tag_i,
  input  logic [NUM_CLUSTERS-1:0][WR_PORTS-1:0][DATA_W-1:0]    wr_data_i
);

  logic                                              rst_sync_n;
  logic [NUM_CLUSTERS-1:0][WR_PORTS-1:0]             xfer_vld;
  logic [NUM_CLUSTERS-1:0][WR_PORTS-1:0][TAG_W-1:0]  xfer_tag;
  logic [NUM_CLUSTERS-1:0][WR_PORTS-1:0][DATA_W-1:0] xfer_data;

  dcrf_rst_sync u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  for (genvar c = 0; c < NUM_CLUSTERS; c++) begin : g_cluster
    localparam int PEER = peer_of(c);

    // Carries this cluster's results to the peer copy.
    dcrf_xfer_stage #(
      .WR_PORTS (WR_PORTS),
      .TAG_W    (TAG_W),
      .DATA_W   (DATA_W)
    ) u_xfer (
      .clk_i       (clk_i),
      .rst_ni      (rst_sync_n),
      .wr_en_i     (wr_en_i[c]),
      .wr_zero_i   (wr_zero_i[c]),
      .wr_tag_i    (wr_tag_i[c]),
      .wr_data_i   (wr_data_i[c]),
      .xfer_vld_o  (xfer_vld[c]),
      .xfer_tag_o  (xfer_tag[c]),
      .xfer_data_o (xfer_data[c])
    );

    // This cluster's copy: own writes now, peer writes from the stage.
    dcrf_bank #(
      .NUM_ENTRIES (NUM_ENTRIES),
      .DATA_W      (DATA_W),
      .RD_PORTS    (RD_PORTS),
      .WR_PORTS    (WR_PORTS),
      .TAG_W       (TAG_W)
    ) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_sync_n),
      .lcl_en_i   (wr_en_i[c]),
      .lcl_zero_i (wr_zero_i[c]),
      .lcl_tag_i  (wr_tag_i[c]),
      .lcl_data_i (wr_data_i[c]),
      .rem_vld_i  (xfer_vld[PEER]),
      .rem_tag_i  (xfer_tag[PEER]),
      .rem_data_i (xfer_data[PEER]),
      .rd_zero_i  (rd_zero_i[c]),
      .rd_tag_i   (rd_tag_i[c]),
      .rd_data_o  (rd_data_o[c])
    );
  end

endmodule

// File: rtl/dcrf_checker.sv
module dcrf_checker
  import dcrf_pkg::*;
#(
  parameter int NUM_ENTRIES = 80,
  parameter int DATA_W      = 64,
  parameter int RD_PORTS    = 4,
  parameter int WR_PORTS    = 2,
  parameter int TAG_W       = 7
) (
  input logic                                              clk_i,
  input logic                                              rst_sync_n,
  input logic [NUM_CLUSTERS-1:0][RD_PORTS-1:0]             rd_zero_i,
  input logic [NUM_CLUSTERS-1:0][RD_PORTS-1:0][TAG_W-1:0]  rd_tag_i,
  input logic [NUM_CLUSTERS-1:0][RD_PORTS-1:0][DATA_W-1:0] rd_data_o,
  input logic [NUM_CLUSTERS-1:0][WR_PORTS-1:0]             wr_en_i,
  input logic [NUM_CLUSTERS-1:0][WR_PORTS-1:0]             wr_zero_i,
  input logic [NUM_CLUSTERS-1:0][WR_PORTS-1:0][TAG_W-1:0]  wr_tag_i,
  input logic [NUM_CLUSTERS-1:0][WR_PORTS-1:0][DATA_W-1:0] wr_data_i,
  input logic [NUM_CLUSTERS-1:0][WR_PORTS-1:0]             xfer_vld,
  input logic [NUM_CLUSTERS-1:0][WR_PORTS-1:0][TAG_W-1:0]  xfer_tag,
  input logic [NUM_CLUSTERS-1:0][WR_PORTS-1:0][DATA_W-1:0] xfer_data
);

  localparam logic [TAG_W-1:0] LAST_TAG = TAG_W'(NUM_ENTRIES - 1);
  localparam int TOP_WR = WR_PORTS - 1;

  for (genvar c = 0; c < NUM_CLUSTERS; c++) begin : g_cl
    localparam int PEER = peer_of(c);

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
      assert_zero_read_R2 : assert property (@(posedge clk_i) disable iff (!rst_sync_n)
        rd_zero_i[c][p] |-> (rd_data_o[c][p] == '0));

      // highest-priority local write port must always be forwarded
      assert_local_bypass_R4 : assert property (@(posedge clk_i) disable iff (!rst_sync_n)
        (wr_en_i[c][TOP_WR] && !wr_zero_i[c][TOP_WR] && !rd_zero_i[c][p] &&
         (wr_tag_i[c][TOP_WR] <= LAST_TAG) && (rd_tag_i[c][p] == wr_tag_i[c][TOP_WR]))
        |-> (rd_data_o[c][p] == wr_data_i[c][TOP_WR]));
    end

    for (genvar w = 0; w < WR_PORTS; w++) begin : g_wr
      assert_remote_capture_R5 : assert property (@(posedge clk_i) disable iff (!rst_sync_n)
        (wr_en_i[c][w] && !wr_zero_i[c][w]) |=>
        (xfer_vld[c][w] && (xfer_tag[c][w] == $past(wr_tag_i[c][w])) &&
         (xfer_data[c][w] == $past(wr_data_i[c][w]))));

      assert_zero_write_quiet_R3 : assert property (@(posedge clk_i) disable iff (!rst_sync_n)
        (!wr_en_i[c][w] || wr_zero_i[c][w]) |=> !xfer_vld[c][w]);

      for (genvar v = 0; v < WR_PORTS; v++) begin : g_col
        assert_no_collision_R9 : assert property (@(posedge clk_i) disable iff (!rst_sync_n)
          !(wr_en_i[c][w] && !wr_zero_i[c][w] && xfer_vld[PEER][v] &&
            (wr_tag_i[c][w] == xfer_tag[PEER][v])));
      end
    end
  end

endmodule

bind dual_copy_int_regfile dcrf_checker #(
  .NUM_ENTRIES (NUM_ENTRIES),
  .DATA_W      (DATA_W),
  .RD_PORTS    (RD_PORTS),
  .WR_PORTS    (WR_PORTS),
  .TAG_W       (TAG_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_sync_n (rst_sync_n),
  .rd_zero_i  (rd_zero_i),
  .rd_tag_i   (rd_tag_i),
  .rd_data_o  (rd_data_o),
  .wr_en_i    (wr_en_i),
  .wr_zero_i  (wr_zero_i),
  .wr_tag_i   (wr_tag_i),
  .wr_data_i  (wr_data_i),
  .xfer_vld   (xfer_vld),
  .xfer_tag   (xfer_tag),
  .xfer_data  (xfer_data)
);

// File: tb/dual_copy_int_regfile_tb_top.sv
`timescale 1ns/1ps
module dual_copy_int_regfile_tb_top;

  localparam int NCL  = 2;
  localparam int RDP  = 4;
  localparam int WRP  = 2;
  localparam int TW   = 7;
  localparam int DW   = 64;
  localparam int NENT = 80;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                             rst_n;
  logic [NCL-1:0][RDP-1:0]          rd_zero;
  logic [NCL-1:0][RDP-1:0][TW-1:0]  rd_tag;
  logic [NCL-1:0][RDP-1:0][DW-1:0]  rd_data;
  logic [NCL-1:0][WRP-1:0]          wr_en;
  logic [NCL-1:0][WRP-1:0]          wr_zero;
  logic [NCL-1:0][WRP-1:0][TW-1:0]  wr_tag;
  logic [NCL-1:0][WRP-1:0][DW-1:0]  wr_data;

  // Reference model: two copies plus the writes waiting to cross over.
  logic [DW-1:0] mdl    [NCL][NENT];
  logic          pend_v [NCL][WRP];
  logic [TW-1:0] pend_t [NCL][WRP];
  logic [DW-1:0] pend_d [NCL][WRP];

  int vectors = 0;
  int miscompares = 0;

  dual_copy_int_regfile dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .rd_zero_i (rd_zero),
    .rd_tag_i  (rd_tag),
    .rd_data_o (rd_data),
    .wr_en_i   (wr_en),
    .wr_zero_i (wr_zero),
    .wr_tag_i  (wr_tag),
    .wr_data_i (wr_data)
  );

  function automatic logic [DW-1:0] exp_rd(input int c, input logic [TW-1:0] t, input logic z);
    logic [DW-1:0] v;
    if (z || int'(t) >= NENT) return '0;
    v = mdl[c][t];
    for (int w = 0; w < WRP; w++)
      if (wr_en[c][w] && !wr_zero[c][w] && wr_tag[c][w] == t) v = wr_data[c][w];
    return v;
  endfunction

  // Advance one clock edge and update the model with the same skew.
  task automatic tick();
    @(posedge clk);
    for (int c = 0; c < NCL; c++)
      for (int w = 0; w < WRP; w++)
        if (pend_v[c][w] && int'(pend_t[c][w]) < NENT) mdl[c][pend_t[c][w]] = pend_d[c][w];
    for (int c = 0; c < NCL; c++)
      for (int w = 0; w < WRP; w++)
        if (wr_en[c][w] && !wr_zero[c][w] && int'(wr_tag[c][w]) < NENT)
          mdl[c][wr_tag[c][w]] = wr_data[c][w];
    for (int c = 0; c < NCL; c++)
      for (int w = 0; w < WRP; w++) begin
        pend_v[c][w] = wr_en[1-c][w] && !wr_zero[1-c][w];
        pend_t[c][w] = wr_tag[1-c][w];
        pend_d[c][w] = wr_data[1-c][w];
      end
    #1;
    wr_en   = '0;
    wr_zero = '0;
    rd_zero = '0;
  endtask

  task automatic put(input int c, input int w, input logic [TW-1:0] t,
                     input logic [DW-1:0] d, input logic z = 1'b0);
    wr_en[c][w]   = 1'b1;
    wr_zero[c][w] = z;
    wr_tag[c][w]  = t;
    wr_data[c][w] = d;
  endtask

  task automatic chk(input int c, input int p, input logic [TW-1:0] t,
                     input logic z, input string req);
    logic [DW-1:0] e;
    rd_tag[c][p]  = t;
    rd_zero[c][p] = z;
    #0.1;
    e = exp_rd(c, t, z);
    vectors++;
    if (rd_data[c][p] !== e) begin
      miscompares++;
      $display("FAIL %s: cluster %0d port %0d tag %0d zero %0b got %h expected %h",
               req, c, p, t, z, rd_data[c][p], e);
    end
  endtask

  // R1: every entry of both copies is zero after reset
  task automatic t_reset_state();
    for (int b = 0; b < NENT; b += RDP) begin
      for (int c = 0; c < NCL; c++)
        for (int p = 0; p < RDP; p++) chk(c, p, TW'(b + p), 1'b0, "R1");
      tick();
    end
  endtask

  // R2: zero-select reads return zero even over stored / bypassed data
  task automatic t_zero_read();
    put(0, 0, 7'd5, 64'hDEAD_BEEF_0123_4567);
    chk(0, 1, 7'd5, 1'b1, "R2");
    tick(); tick();
    chk(0, 0, 7'd5, 1'b1, "R2");
    chk(1, 2, 7'd5, 1'b1, "R2");
    chk(1, 3, 7'd5, 1'b0, "R2");
  endtask

  // R3: zero-select writes touch neither copy
  task automatic t_zero_write();
    put(1, 1, 7'd7, '1, 1'b1);
    chk(1, 0, 7'd7, 1'b0, "R3");
    tick(); tick();
    chk(0, 0, 7'd7, 1'b0, "R3");
    chk(1, 2, 7'd7, 1'b0, "R3");
  endtask

  // R4, R5, R6: local bypass, one-cycle skew into the peer, then agreement
  task automatic t_skew();
    put(0, 0, 7'd40, 64'hA5A5_0000_1111_2222);
    chk(0, 2, 7'd40, 1'b0, "R4");
    chk(1, 0, 7'd40, 1'b0, "R5");
    tick();
    chk(0, 1, 7'd40, 1'b0, "R4");
    chk(1, 1, 7'd40, 1'b0, "R5");
    tick();
    chk(1, 2, 7'd40, 1'b0, "R6");
    chk(0, 3, 7'd40, 1'b0, "R6");
    put(1, 1, 7'd75, 64'h0F0F_3333_4444_5555);
    chk(1, 3, 7'd75, 1'b0, "R4");
    chk(0, 0, 7'd75, 1'b0, "R5");
    tick();
    chk(0, 1, 7'd75, 1'b0, "R5");
    tick();
    chk(0, 2, 7'd75, 1'b0, "R6");
    chk(1, 0, 7'd75, 1'b0, "R6");
  endtask

  // R7: both ports of one cluster on one tag, port 1 wins
  task automatic t_priority();
    put(1, 0, 7'd10, 64'h1111_1111_1111_1111);
    put(1, 1, 7'd10, 64'h2222_2222_2222_2222);
    chk(1, 0, 7'd10, 1'b0, "R7");
    tick(); tick();
    chk(0, 0, 7'd10, 1'b0, "R7");
    chk(1, 3, 7'd10, 1'b0, "R7");
  endtask

  // R8: range edges of all groups, and out-of-range tags
  task automatic t_groups();
    int tags [6] = '{0, 31, 32, 71, 72, 79};
    for (int i = 0; i < 6; i++) begin
      put(i % 2, (i / 2) % 2, TW'(tags[i]), {8{8'(tags[i])}} ^ 64'hC3C3_0000_FFFF_0000);
      tick();
    end
    tick(); tick();
    for (int i = 0; i < 6; i++) begin
      chk(0, i % RDP, TW'(tags[i]), 1'b0, "R8");
      chk(1, i % RDP, TW'(tags[i]), 1'b0, "R8");
    end
    put(0, 1, 7'd100, 64'h7777_8888_9999_AAAA);
    chk(0, 0, 7'd100, 1'b0, "R8");
    tick(); tick();
    chk(1, 0, 7'd100, 1'b0, "R8");
    chk(0, 1, 7'd20, 1'b0, "R8");
    chk(1, 1, 7'd36, 1'b0, "R8");
    chk(0, 2, 7'd36, 1'b0, "R8");
  endtask

  // R4, R5: both clusters writing every cycle, reads straddling the skew
  task automatic t_stream();
    for (int k = 0; k < 10; k++) begin
      for (int c = 0; c < NCL; c++)
        for (int w = 0; w < WRP; w++)
          put(c, w, TW'(k * 4 + c * 2 + w), {16'(k), 16'(c), 16'(w), 16'hBEEF});
      for (int c = 0; c < NCL; c++) begin
        chk(c, 0, TW'(k * 4 + c * 2), 1'b0, "R4");
        chk(c, 1, TW'(k * 4 + c * 2 + 1), 1'b0, "R4");
        if (k > 0) begin
          chk(c, 2, TW'((k - 1) * 4 + (1 - c) * 2), 1'b0, "R5");
          chk(c, 3, TW'((k - 1) * 4 + (1 - c) * 2 + 1), 1'b0, "R5");
        end
      end
      tick();
    end
    tick(); tick();
    for (int t = 0; t < 40; t++) begin
      chk(0, t % RDP, TW'(t), 1'b0, "R6");
      chk(1, t % RDP, TW'(t), 1'b0, "R6");
      tick();
    end
  endtask

  initial begin
    rst_n   = 1'b0;
    rd_zero = '0;
    rd_tag  = '0;
    wr_en   = '0;
    wr_zero = '0;
    wr_tag  = '0;
    wr_data = '0;
    for (int c = 0; c < NCL; c++) begin
      for (int i = 0; i < NENT; i++) mdl[c][i] = '0;
      for (int w = 0; w < WRP; w++) begin
        pend_v[c][w] = 1'b0;
        pend_t[c][w] = '0;
        pend_d[c][w] = '0;
      end
    end
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    t_reset_state();
    t_zero_read();
    t_zero_write();
    t_skew();
    t_priority();
    t_groups();
    t_stream();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule